// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sits on the host side of a three-wire write link to a 16-bit voltage-output converter. It takes a parallel request, a 16-bit output code plus a 2-bit operating-mode field, and turns it into one 24-bit serial frame on an active-low frame-select line, a serial clock and a data line. All three wires come from the system clock. A parameterised divider sets the clock phases. Counted intervals cover the select-to-clock setup and the select-high gap between frames.

The requester uses a valid/ready handshake: a request is taken only while the block is idle. The code, mode and split flag are captured at that point, so later changes on the request inputs do not matter. A single-cycle done pulse marks the end of the select-high gap, which is when the next frame may start. A per-request split flag sends the frame as three 8-clock bursts with idle pauses between them. The select line stays low across the whole frame, as a byte-oriented serial port would produce.

The clock idles low. Data changes one system cycle after each falling clock edge, and the receiver samples it on the following falling edge. The block derives all phase lengths from the system clock period and the timing minimums given as parameters in nanoseconds.

Top module: `dacfr_tx`

## Requirements
- R1: While reset is asserted and right after it is released, the select line is high, the serial clock is low, ready is high and done is low.
- R2: A frame carries 24 bits, most significant first: six zero bits, then the 2-bit mode, then the 16-bit code. A receiver that shifts the data line on each falling clock edge holds {6'b0, mode, code} after the 24th edge.
- R3: Within a frame, the data line changes only in a cycle where the serial clock is low and was low in the previous cycle. It therefore never changes at a falling edge.
- R4: Every high phase and every low phase between clock edges lasts at least HALF_CYC system cycles, with HALF_CYC >= 2 and HALF_CYC*CLK_NS at least the minimum phase time and half the minimum period.
- R5: The select line is low for at least SETUP_CYC system cycles (SETUP_CYC*CLK_NS >= setup minimum) before the first rising clock edge. The clock never rises while select is high.
- R6: Each select-low window contains exactly 24 falling clock edges, and select rises only after the 24th.
- R7: After select rises it stays high for at least GAP_CYC system cycles (GAP_CYC*CLK_NS >= gap minimum) before it can fall again.
- R8: Ready is high only in the idle state. A request is accepted on a clock edge where valid and ready are both high. Ready is low from acceptance until done. Done is a one-cycle pulse issued together with ready's return. Valid asserted while busy starts no frame, and request inputs that change after acceptance do not alter the frame in flight.
- R9: With the split flag captured high, the clock stays low for an extra PAUSE_CYC cycles after the 8th and 16th falling edges while select stays low. With it low, no pause occurs.
- R10: The serial clock is low whenever the select line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_code | input | CODE_W | Output code to send |
| req_mode | input | MODE_W | Operating-mode field to send |
| req_split | input | 1 | Send the frame as three byte bursts |
| done | output | 1 | One-cycle pulse at the end of the post-frame gap |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_sck | output | 1 | Serial clock, idle low |
| dac_sdo | output | 1 | Serial data, sampled by the receiver on falling clock edges |

## Verification
The assertions assume a clean synchronous reset release. They also assume the requester treats ready as the only acceptance condition: valid may be held while the block is busy, but it has no meaning there. The stimulus drives valid and the request fields only on falling system-clock edges. It keeps valid high while busy in only one directed case. A receiver model in the bench decodes the wires. A separate injected frame is aborted by raising select after ten clock edges. That frame is driven into the model only while the block is idle, so the block's own outputs never break the timing assumptions.

// File: rtl/dacfr_pkg.sv
package dacfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_PAUSE,
    ST_GAP
  } seq_st_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacfr_timer.sv
module dacfr_timer #(
  parameter int TMR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             last
);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (load) begin
      cnt_nx = load_val;
    end else if (cnt_q != '0) begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/dacfr_shifter.sv
module dacfr_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift,
  output logic               msb
);

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_nx;

  always_comb begin
    sr_nx = sr_q;
    if (load) begin
      sr_nx = load_word;
    end else if (shift) begin
      sr_nx = {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_nx;
    end
  end

  assign msb = sr_q[FRAME_W-1];

endmodule

// File: rtl/dacfr_seq.sv
module dacfr_seq
  import dacfr_pkg::*;
#(
  parameter int FRAME_W   = 24,
  parameter int BURST_W   = 8,
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 1,
  parameter int GAP_CYC   = 2,
  parameter int PAUSE_CYC = 4,
  parameter int TMR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_split,
  output logic             req_ready,
  output logic             frame_load,
  output logic             frame_shift,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             sync_n,
  output logic             sck,
  output logic             done
);

  localparam int FC_W = $clog2(FRAME_W + 1);
  localparam int BC_W = $clog2(BURST_W);
  localparam logic [FC_W-1:0]  FALLS_ALL  = FC_W'(FRAME_W);
  localparam logic [BC_W-1:0]  BURST_LAST = BC_W'(BURST_W - 1);
  localparam logic [TMR_W-1:0] T_HALF  = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_GAP   = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] T_PAUSE = TMR_W'(PAUSE_CYC - 1);

  seq_st_t         st_q, st_nx;
  logic [FC_W-1:0] falls_q, falls_nx;
  logic [BC_W-1:0] burst_q, burst_nx;
  logic            split_q, split_nx;
  logic            fell_q, fell_nx;
  logic            sync_n_q, sck_q, done_q;
  logic            done_nx;

  always_comb begin
    st_nx      = st_q;
    falls_nx   = falls_q;
    burst_nx   = burst_q;
    split_nx   = split_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    frame_load = 1'b0;
    done_nx    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_nx      = ST_SETUP;
          tmr_load   = 1'b1;
          tmr_val    = T_SETUP;
          falls_nx   = '0;
          burst_nx   = '0;
          split_nx   = req_split;
          frame_load = 1'b1;
        end
      end
      ST_SETUP, ST_PAUSE: begin
        if (tmr_last) begin
          st_nx    = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
        end
      end
      ST_HIGH: begin
        if (tmr_last) begin
          st_nx    = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
          falls_nx = falls_q + 1'b1;
          burst_nx = (burst_q == BURST_LAST) ? '0 : burst_q + 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          if (falls_q == FALLS_ALL) begin
            st_nx   = ST_GAP;
            tmr_val = T_GAP;
          end else if (split_q && (burst_q == '0)) begin
            st_nx   = ST_PAUSE;
            tmr_val = T_PAUSE;
          end else begin
            st_nx   = ST_HIGH;
            tmr_val = T_HALF;
          end
        end
      end
      ST_GAP: begin
        if (tmr_last) begin
          st_nx   = ST_IDLE;
          done_nx = 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign fell_nx = (st_q == ST_HIGH) && (st_nx == ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      falls_q  <= '0;
      burst_q  <= '0;
      split_q  <= 1'b0;
      fell_q   <= 1'b0;
      sync_n_q <= 1'b1;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_nx;
      falls_q  <= falls_nx;
      burst_q  <= burst_nx;
      split_q  <= split_nx;
      fell_q   <= fell_nx;
      sync_n_q <= (st_nx == ST_IDLE) || (st_nx == ST_GAP);
      sck_q    <= (st_nx == ST_HIGH);
      done_q   <= done_nx;
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign frame_shift = fell_q;
  assign sync_n      = sync_n_q;
  assign sck         = sck_q;
  assign done        = done_q;

endmodule

// File: rtl/dacfr_tx.sv
module dacfr_tx
  import dacfr_pkg::*;
#(
  parameter int CODE_W            = 16,
  parameter int MODE_W            = 2,
  parameter int PAD_W             = 6,
  parameter int BURST_W           = 8,
  parameter int CLK_NS            = 20,
  parameter int SCK_HALF_MIN_NS   = 13,
  parameter int SCK_PERIOD_MIN_NS = 50,
  parameter int SETUP_MIN_NS      = 13,
  parameter int GAP_MIN_NS        = 33,
  parameter int PAUSE_CYC         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_split,
  output logic              done,
  output logic              dac_sync_n,
  output logic              dac_sck,
  output logic              dac_sdo
);

  localparam int FRAME_W   = PAD_W + MODE_W + CODE_W;
  localparam int HALF_NS   = imax(SCK_HALF_MIN_NS, cdiv(SCK_PERIOD_MIN_NS, 2));
  localparam int HALF_CYC  = imax(2, cdiv(HALF_NS, CLK_NS));
  localparam int SETUP_CYC = imax(1, cdiv(SETUP_MIN_NS, CLK_NS));
  localparam int GAP_CYC   = imax(1, cdiv(GAP_MIN_NS, CLK_NS));
  localparam int PAUSE_EFF = imax(1, PAUSE_CYC);
  localparam int TMR_MAX   = imax(imax(HALF_CYC, SETUP_CYC), imax(GAP_CYC, PAUSE_EFF));
  localparam int TMR_W     = $clog2(TMR_MAX + 1);

  logic             frame_load;
  logic             frame_shift;
  logic             tmr_load;
  logic             tmr_last;
  logic [TMR_W-1:0] tmr_val;

  dacfr_seq #(
    .FRAME_W  (FRAME_W),
    .BURST_W  (BURST_W),
    .HALF_CYC (HALF_CYC),
    .SETUP_CYC(SETUP_CYC),
    .GAP_CYC  (GAP_CYC),
    .PAUSE_CYC(PAUSE_EFF),
    .TMR_W    (TMR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_split  (req_split),
    .req_ready  (req_ready),
    .frame_load (frame_load),
    .frame_shift(frame_shift),
    .tmr_last   (tmr_last),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .sync_n     (dac_sync_n),
    .sck        (dac_sck),
    .done       (done)
  );

  dacfr_timer #(
    .TMR_W(TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .last    (tmr_last)
  );

  dacfr_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_load),
    .load_word({{PAD_W{1'b0}}, req_mode, req_code}),
    .shift    (frame_shift),
    .msb      (dac_sdo)
  );

endmodule

// File: rtl/dacfr_tx_chk.sv
module dacfr_tx_chk #(
  parameter int FRAME_W  = 24,
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic dac_sync_n,
  input logic dac_sck,
  input logic dac_sdo
);

  localparam int CW = 8;
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] hi_run, lo_run, gap_run, win_falls;
  logic          sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      gap_run   <= SAT;
      win_falls <= '0;
      sck_d     <= 1'b0;
    end else begin
      sck_d     <= dac_sck;
      hi_run    <= !dac_sck ? '0 : ((hi_run == SAT) ? SAT : hi_run + 1'b1);
      lo_run    <= dac_sck ? '0 : ((lo_run == SAT) ? SAT : lo_run + 1'b1);
      gap_run   <= !dac_sync_n ? '0 : ((gap_run == SAT) ? SAT : gap_run + 1'b1);
      win_falls <= dac_sync_n ? '0 : ((sck_d && !dac_sck) ? win_falls + 1'b1 : win_falls);
    end
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sync_n |-> !dac_sck);  // R10

  AST_DATA_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_sync_n && $past(!dac_sync_n) && (dac_sdo != $past(dac_sdo))) |-> (!dac_sck && !$past(dac_sck)));  // R3

  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sck) |-> (hi_run >= CW'(HALF_CYC)));  // R4

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_sck) |-> (lo_run >= CW'(HALF_CYC)));  // R4

  AST_SETUP_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_sck) |-> $past(!dac_sync_n));  // R5

  AST_SYNC_RISE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_sync_n) |-> (win_falls == CW'(FRAME_W)));  // R6

  AST_NO_EXTRA_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sck) |-> (win_falls < CW'(FRAME_W)));  // R6

  AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sync_n) |-> (gap_run >= CW'(GAP_CYC)));  // R7

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);  // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_sync_n |-> !req_ready);  // R8

endmodule

bind dacfr_tx dacfr_tx_chk #(
  .FRAME_W (FRAME_W),
  .HALF_CYC(HALF_CYC),
  .GAP_CYC (GAP_CYC)
) u_dacfr_tx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .dac_sync_n(dac_sync_n),
  .dac_sck   (dac_sck),
  .dac_sdo   (dac_sdo)
);

// File: tb/dacfr_tx_bench.sv
`timescale 1ns/1ps
module dacfr_tx_bench;

  localparam int EXP_HALF  = 2;   // 50 ns period at 20 ns clock
  localparam int EXP_SETUP = 1;   // 13 ns setup
  localparam int EXP_GAP   = 2;   // 33 ns gap
  localparam int EXP_PAUSE = 4;
  localparam int NVEC      = 7;

  // {split, mode, code, expected frame, expected pause count}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 16'hFFFF, 24'h00FFFF, 2'd0},
    {1'b0, 2'b01, 16'h8001, 24'h018001, 2'd0},
    {1'b1, 2'b10, 16'h5AA5, 24'h025AA5, 2'd2},
    {1'b0, 2'b11, 16'h0001, 24'h030001, 2'd0},
    {1'b1, 2'b00, 16'hFFFF, 24'h00FFFF, 2'd2},
    {1'b1, 2'b11, 16'h8000, 24'h038000, 2'd2},
    {1'b0, 2'b00, 16'h1234, 24'h001234, 2'd0}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_code;
  logic [1:0]  req_mode;
  logic        req_split;
  logic        done;
  logic        dac_sync_n;
  logic        dac_sck;
  logic        dac_sdo;

  int checks = 0;
  int errors = 0;

  dacfr_tx u_dacfr_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_code  (req_code),
    .req_mode  (req_mode),
    .req_split (req_split),
    .done      (done),
    .dac_sync_n(dac_sync_n),
    .dac_sck   (dac_sck),
    .dac_sdo   (dac_sdo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // receiver model, fed by the design or by an injected frame
  logic inj, inj_fs, inj_sck, inj_sdo;
  logic m_fs, m_sck, m_sdo;
  assign m_fs  = inj ? inj_fs  : dac_sync_n;
  assign m_sck = inj ? inj_sck : dac_sck;
  assign m_sdo = inj ? inj_sdo : dac_sdo;

  logic        fs_prev, sck_prev, seen_rise;
  logic [23:0] rx_sh, rx_reg;
  int frames_got, win, frame_falls, run, setup_len, min_hi, min_lo, longs, gap_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      fs_prev <= 1'b1; sck_prev <= 1'b0; seen_rise <= 1'b0;
      rx_sh <= '0; rx_reg <= '0; frames_got <= 0; win <= 0; frame_falls <= 0;
      run <= 0; setup_len <= 0; min_hi <= 99; min_lo <= 99; longs <= 0; gap_cnt <= 0;
    end else begin
      fs_prev  <= m_fs;
      sck_prev <= m_sck;
      if (!m_fs) begin
        if (fs_prev) begin
          run <= 1; seen_rise <= 1'b0; win <= 0; min_hi <= 99; min_lo <= 99; longs <= 0;
        end else if (m_sck != sck_prev) begin
          run <= 1;
          if (sck_prev) begin
            if (run < min_hi) min_hi <= run;
            rx_sh <= {rx_sh[22:0], m_sdo};
            win <= win + 1;
            if (win == 23) begin
              rx_reg <= {rx_sh[22:0], m_sdo};
              frames_got <= frames_got + 1;
            end
          end else if (!seen_rise) begin
            setup_len <= run;
            seen_rise <= 1'b1;
          end else begin
            if (run < min_lo) min_lo <= run;
            if (run > EXP_HALF) longs <= longs + 1;
          end
        end else begin
          run <= run + 1;
        end
      end else begin
        if (!fs_prev) begin
          frame_falls <= win;
          win <= 0;
          gap_cnt <= 1;
        end else begin
          gap_cnt <= gap_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic accept(input logic [15:0] c, input logic [1:0] m, input logic s);
    req_code = c; req_mode = m; req_split = s; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_code  = ~c;              // R8: late changes must not reach the frame
    req_mode  = ~m;
    chk(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
  endtask

  task automatic frame_checks(input logic [23:0] exp_frame, input int exp_longs, input int f0);
    logic seen;
    wait_done(seen);
    chk(seen, "R8 done pulse seen", int'(seen), 1);
    chk(req_ready, "R8 ready with done", int'(req_ready), 1);
    chk(rx_reg == exp_frame, "R2 decoded frame", int'(rx_reg), int'(exp_frame));
    chk(frames_got == f0 + 1, "R2 one frame latched", frames_got, f0 + 1);
    chk(frame_falls == 24, "R6 falling edges per window", frame_falls, 24);
    chk(setup_len >= EXP_SETUP, "R5 setup cycles", setup_len, EXP_SETUP);
    chk(min_hi >= EXP_HALF, "R4 high phase", min_hi, EXP_HALF);
    chk(min_lo >= EXP_HALF, "R4 low phase", min_lo, EXP_HALF);
    chk(longs == exp_longs, "R9 burst pauses", longs, exp_longs);
    chk(gap_cnt >= EXP_GAP, "R7 select high gap", gap_cnt, EXP_GAP);
    @(negedge clk);
    chk(!done, "R8 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    logic seen;
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_mode = '0; req_split = 1'b0;
    inj = 1'b0; inj_fs = 1'b1; inj_sck = 1'b0; inj_sdo = 1'b0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(dac_sync_n && !dac_sck && req_ready && !done, "R1 reset outputs",
        {dac_sync_n, dac_sck, req_ready, done}, 4'b1010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_sync_n && !dac_sck && req_ready && !done, "R1 after release",
        {dac_sync_n, dac_sck, req_ready, done}, 4'b1010);

    // table-driven frames, back to back (R2 R4 R5 R6 R7 R8 R9)
    for (int v = 0; v < NVEC; v++) begin
      f0 = frames_got;
      accept(VEC[v][41:26], VEC[v][43:42], VEC[v][44]);
      frame_checks(VEC[v][25:2], int'(VEC[v][1:0]), f0);
    end

    // R8: valid held high while busy starts no extra frame
    f0 = frames_got;
    accept(16'hC3C3, 2'b01, 1'b0);
    req_code = 16'h0F0F; req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(rx_reg == 24'h01C3C3, "R8 busy valid ignored frame", int'(rx_reg), 24'h01C3C3);
    repeat (20) @(negedge clk);
    chk(frames_got == f0 + 1 && dac_sync_n, "R8 no extra frame", frames_got, f0 + 1);

    // R10: idle clock stays low
    chk(!dac_sck && dac_sync_n, "R10 idle clock low", int'(dac_sck), 0);

    // aborted frame into the receiver model leaves its register unchanged (R6 rule)
    f0 = frames_got;
    @(posedge clk);
    inj = 1'b1;
    @(posedge clk); inj_fs = 1'b0;
    for (int b = 0; b < 10; b++) begin
      inj_sdo = b[0];
      @(posedge clk); @(posedge clk); inj_sck = 1'b1;
      @(posedge clk); @(posedge clk); inj_sck = 1'b0;
    end
    @(posedge clk); @(posedge clk); inj_fs = 1'b1;
    repeat (3) @(posedge clk);
    inj = 1'b0;
    @(negedge clk);
    chk(rx_reg == 24'h01C3C3, "R6 aborted frame ignored", int'(rx_reg), 24'h01C3C3);
    chk(frames_got == f0, "R6 aborted frame not counted", frames_got, f0);

    // a following real frame still decodes after the abort
    f0 = frames_got;
    accept(16'h7FFF, 2'b10, 1'b1);
    frame_checks(24'h027FFF, 2, f0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule